// File: doc/BRIEF.md
# Boundary-Scan Wrapped Dual Byte Transceiver

This block is the system datapath of a two-lane, nine-bit, non-inverting bidirectional transceiver together with the boundary register that wraps its pins. Each lane has an A side and a B side, each with separate input, output and output-enable signals, plus an active-low lane enable and a direction select. In normal operation the core logic steers the data of each lane from one side to the other and drives the enable of exactly one side, or of neither.

An 80-cell boundary register sits between the pins and the core. Under capture, shift and update strobes from an external test controller, it samples pins and core results, moves data serially from a test data input toward a test data output, and latches values into update cells. When test-drive mode is selected, the four side enables and all output pins are driven from those update cells instead of from the core. The test controller state machine and instruction decode sit outside this block and reach it only as strobes and a mode select.

Top module: `bscan_dual_xcvr`

## Requirements
- R1: In normal mode (drive_mode=0), a lane whose lane_oe_n bit is 1 has both its a_oe and b_oe bits at 0, whatever its lane_dir bit is.
- R2: In normal mode, a lane with lane_oe_n=0 and lane_dir=0 has a_oe=1 and b_oe=0, and with lane_dir=1 has a_oe=0 and b_oe=1; a_out of a lane always carries that lane's b_in, and b_out carries its a_in, without inversion.
- R3: A capture strobe loads all 80 cells in one cycle. Cell 79-4L holds lane_dir of lane L, 78-4L holds lane_oe_n, 77-4L holds the A-side enable and 76-4L the B-side enable that the core is computing. Bit k of lane L goes to cell 71-9L-k for a_in, 53-9L-k for the core's b_out value, 35-9L-k for b_in, and 17-9L-k for the core's a_out value.
- R4: A shift strobe moves every cell one place toward cell 0, with tdi entering cell 79. tdo always shows cell 0, so a bit shifted in reappears on tdo after exactly 80 shifts. Capture takes priority over shift.
- R5: An update strobe copies the output cells (53..36 and 17..0) and the four internal enable cells (77, 76, 73, 72) into update latches. In drive mode, each a_out, b_out, a_oe and b_oe bit equals the latch that belongs to its cell as placed in R3.
- R6: In normal mode the update latches have no effect on any output; outputs follow R1 and R2.
- R7: The update latches hold their value through capture and shift activity. They change only on the update strobe or the test reset.
- R8: A test reset strobe (tst_rst=1 for one cycle) clears every update latch to 0, so in drive mode all outputs and enables read 0. It has priority over update.
- R9: While rst_n is low, every cell and latch is cleared, so tdo reads 0 and drive mode presents all zeros. rst_n is asserted asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_mode | input | 1 | 1 selects update latches as source of outputs and enables |
| cap_en | input | 1 | Capture strobe for the boundary register |
| shf_en | input | 1 | Shift strobe for the boundary register |
| upd_en | input | 1 | Update strobe loading the update latches |
| tst_rst | input | 1 | Synchronous clear of the update latches |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, cell 0 |
| lane_oe_n | input | 2 | Active-low enable per lane |
| lane_dir | input | 2 | Direction per lane, 1 = A to B |
| a_in | input | 18 | A-side pin inputs, lane L in bits 9L+8..9L |
| a_out | output | 18 | A-side pin outputs |
| a_oe | output | 2 | A-side output enable per lane, active high |
| b_in | input | 18 | B-side pin inputs |
| b_out | output | 18 | B-side pin outputs |
| b_oe | output | 2 | B-side output enable per lane, active high |

## Verification
The hardest state to reach is one where the update latches disagree with what the core would present, because the latches can be loaded only by a full 80-bit serial scan followed by an update strobe. The bench scans in bit patterns whose enable and data cells differ from the live core result, then toggles drive mode to show the pins switching between the two sources. It also scans a second pattern in without updating, so a latch that leaks shift data shows up on the pins. The same scan returns the previous contents on tdo, which checks the 80-shift delay and the cell placement in one pass.

// File: rtl/bscan_xcvr_pkg.sv
package bscan_xcvr_pkg;

  localparam int LANES = 2;

  // data cell groups, from the top of the chain downward
  localparam int GRP_A_IN  = 0;
  localparam int GRP_B_OUT = 1;
  localparam int GRP_B_IN  = 2;
  localparam int GRP_A_OUT = 3;

  // control cell slots within one lane's group of four
  localparam int SLOT_DIR = 0;
  localparam int SLOT_G   = 1;
  localparam int SLOT_AOE = 2;
  localparam int SLOT_BOE = 3;

  // index of data bit 'bitn' of 'lane' in group 'grp'; bit 0 sits highest
  function automatic int grp_idx(int w, int grp, int lane, int bitn);
    return (4 - grp) * LANES * w - 1 - w * lane - bitn;
  endfunction

  // index of a control cell; control cells occupy the top of the chain
  function automatic int ctl_idx(int w, int lane, int slot);
    return 4 * LANES * w + 4 * LANES - 1 - 4 * lane - slot;
  endfunction

endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/bscan_core.sv
module bscan_core
  import bscan_xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [LANES-1:0]   oe_n,
  input  logic [LANES-1:0]   dir,
  input  logic [LANES*W-1:0] a_in,
  input  logic [LANES*W-1:0] b_in,
  output logic [LANES*W-1:0] a_data,
  output logic [LANES*W-1:0] b_data,
  output logic [LANES-1:0]   aoe,
  output logic [LANES-1:0]   boe
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign a_data[l*W +: W] = b_in[l*W +: W];
    assign b_data[l*W +: W] = a_in[l*W +: W];
    assign aoe[l] = ~oe_n[l] & ~dir[l];
    assign boe[l] = ~oe_n[l] &  dir[l];
  end
endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
  import bscan_xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_en,
  input  logic                        shf_en,
  input  logic                        upd_en,
  input  logic                        tst_rst,
  input  logic                        tdi,
  input  logic [4*LANES*(W+1)-1:0]    cap_vec,
  output logic                        tdo,
  output logic [LANES*W-1:0]          upd_a,
  output logic [LANES*W-1:0]          upd_b,
  output logic [LANES-1:0]            upd_aoe,
  output logic [LANES-1:0]            upd_boe
);
  localparam int LEN = 4 * LANES * (W + 1);

  logic [LEN-1:0]     sr_d, sr_q;
  logic [LANES*W-1:0] ua_d, ua_q, ub_d, ub_q;
  logic [LANES-1:0]   uaoe_d, uaoe_q, uboe_d, uboe_q;

  always_comb begin
    sr_d = sr_q;
    if (cap_en)      sr_d = cap_vec;
    else if (shf_en) sr_d = {tdi, sr_q[LEN-1:1]};
  end

  always_comb begin
    ua_d   = ua_q;
    ub_d   = ub_q;
    uaoe_d = uaoe_q;
    uboe_d = uboe_q;
    if (tst_rst) begin
      ua_d   = '0;
      ub_d   = '0;
      uaoe_d = '0;
      uboe_d = '0;
    end else if (upd_en) begin
      for (int l = 0; l < LANES; l++) begin
        for (int k = 0; k < W; k++) begin
          ua_d[l*W+k] = sr_q[grp_idx(W, GRP_A_OUT, l, k)];
          ub_d[l*W+k] = sr_q[grp_idx(W, GRP_B_OUT, l, k)];
        end
        uaoe_d[l] = sr_q[ctl_idx(W, l, SLOT_AOE)];
        uboe_d[l] = sr_q[ctl_idx(W, l, SLOT_BOE)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      ua_q   <= '0;
      ub_q   <= '0;
      uaoe_q <= '0;
      uboe_q <= '0;
    end else begin
      sr_q   <= sr_d;
      ua_q   <= ua_d;
      ub_q   <= ub_d;
      uaoe_q <= uaoe_d;
      uboe_q <= uboe_d;
    end
  end

  assign tdo     = sr_q[0];
  assign upd_a   = ua_q;
  assign upd_b   = ub_q;
  assign upd_aoe = uaoe_q;
  assign upd_boe = uboe_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (sr_q == $past(cap_vec)));                               // R3
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en && !cap_en) |=> (sr_q[LEN-1] == $past(tdi)));               // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !tst_rst) |=> $stable({ua_q, ub_q, uaoe_q, uboe_q}));  // R7
  AST_TRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tst_rst |=> ({ua_q, ub_q, uaoe_q, uboe_q} == '0));                  // R8
endmodule

// File: rtl/bscan_dual_xcvr.sv
module bscan_dual_xcvr
  import bscan_xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               drive_mode,
  input  logic               cap_en,
  input  logic               shf_en,
  input  logic               upd_en,
  input  logic               tst_rst,
  input  logic               tdi,
  output logic               tdo,
  input  logic [LANES-1:0]   lane_oe_n,
  input  logic [LANES-1:0]   lane_dir,
  input  logic [LANES*W-1:0] a_in,
  output logic [LANES*W-1:0] a_out,
  output logic [LANES-1:0]   a_oe,
  input  logic [LANES*W-1:0] b_in,
  output logic [LANES*W-1:0] b_out,
  output logic [LANES-1:0]   b_oe
);
  localparam int CHAIN_LEN = 4 * LANES * (W + 1);

  logic                 rst_n_s;
  logic [LANES*W-1:0]   core_a, core_b, upd_a, upd_b;
  logic [LANES-1:0]     core_aoe, core_boe, upd_aoe, upd_boe;
  logic [CHAIN_LEN-1:0] cap_vec;

  bscan_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_s)
  );

  bscan_core #(.W(W)) u_core (
    .oe_n   (lane_oe_n),
    .dir    (lane_dir),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_data (core_a),
    .b_data (core_b),
    .aoe    (core_aoe),
    .boe    (core_boe)
  );

  // capture image: pins on observe cells, core results on drive cells
  always_comb begin
    cap_vec = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < W; k++) begin
        cap_vec[grp_idx(W, GRP_A_IN,  l, k)] = a_in[l*W+k];
        cap_vec[grp_idx(W, GRP_B_OUT, l, k)] = core_b[l*W+k];
        cap_vec[grp_idx(W, GRP_B_IN,  l, k)] = b_in[l*W+k];
        cap_vec[grp_idx(W, GRP_A_OUT, l, k)] = core_a[l*W+k];
      end
      cap_vec[ctl_idx(W, l, SLOT_DIR)] = lane_dir[l];
      cap_vec[ctl_idx(W, l, SLOT_G)]   = lane_oe_n[l];
      cap_vec[ctl_idx(W, l, SLOT_AOE)] = core_aoe[l];
      cap_vec[ctl_idx(W, l, SLOT_BOE)] = core_boe[l];
    end
  end

  bscan_bsr #(.W(W)) u_bsr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cap_en  (cap_en),
    .shf_en  (shf_en),
    .upd_en  (upd_en),
    .tst_rst (tst_rst),
    .tdi     (tdi),
    .cap_vec (cap_vec),
    .tdo     (tdo),
    .upd_a   (upd_a),
    .upd_b   (upd_b),
    .upd_aoe (upd_aoe),
    .upd_boe (upd_boe)
  );

  assign a_out = drive_mode ? upd_a   : core_a;
  assign b_out = drive_mode ? upd_b   : core_b;
  assign a_oe  = drive_mode ? upd_aoe : core_aoe;
  assign b_oe  = drive_mode ? upd_boe : core_boe;

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n_s)
      (!drive_mode && lane_oe_n[l]) |-> (!a_oe[l] && !b_oe[l]));        // R1
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n_s)
      (!drive_mode && !lane_oe_n[l]) |-> $countones({a_oe[l], b_oe[l]}) == 1); // R2
  end
endmodule

// File: tb/bscan_dual_xcvr_test.sv
module bscan_dual_xcvr_test;
  localparam int W = 9;
  localparam int NL = 2;
  localparam int LEN = 80;

  logic clk = 1'b0;
  logic rst_n, drive_mode, cap_en, shf_en, upd_en, tst_rst, tdi, tdo;
  logic [NL-1:0]   lane_oe_n, lane_dir, a_oe, b_oe;
  logic [NL*W-1:0] a_in, b_in, a_out, b_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bscan_dual_xcvr #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .drive_mode(drive_mode), .cap_en(cap_en),
    .shf_en(shf_en), .upd_en(upd_en), .tst_rst(tst_rst), .tdi(tdi), .tdo(tdo),
    .lane_oe_n(lane_oe_n), .lane_dir(lane_dir), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // {oe_n, dir, a_in, b_in, exp a_oe, exp b_oe}
  localparam logic [43:0] TBL [6] = '{
    {2'b11, 2'b00, 18'h2A5A5, 18'h15A5A, 2'b00, 2'b00},
    {2'b11, 2'b11, 18'h3FFFF, 18'h00000, 2'b00, 2'b00},
    {2'b00, 2'b00, 18'h12345, 18'h2BCDE, 2'b11, 2'b00},
    {2'b00, 2'b11, 18'h00F0F, 18'h3F0F0, 2'b00, 2'b11},
    {2'b00, 2'b01, 18'h1C71C, 18'h238E3, 2'b10, 2'b01},
    {2'b01, 2'b10, 18'h0A0A0, 18'h35F5F, 2'b00, 2'b10}
  };

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected capture image, built from the cell placement in R3
  function automatic logic [79:0] exp_cap(logic [1:0] oe_n, logic [1:0] dir,
                                          logic [17:0] ai, logic [17:0] bi);
    logic [79:0] v = '0;
    for (int l = 0; l < NL; l++) begin
      for (int k = 0; k < W; k++) begin
        v[71 - 9*l - k] = ai[9*l + k];
        v[53 - 9*l - k] = ai[9*l + k];
        v[35 - 9*l - k] = bi[9*l + k];
        v[17 - 9*l - k] = bi[9*l + k];
      end
      v[79 - 4*l] = dir[l];
      v[78 - 4*l] = oe_n[l];
      v[77 - 4*l] = ~oe_n[l] & ~dir[l];
      v[76 - 4*l] = ~oe_n[l] & dir[l];
    end
    return v;
  endfunction

  function automatic logic [17:0] dec_a(logic [79:0] v);
    logic [17:0] r;
    for (int l = 0; l < NL; l++) for (int k = 0; k < W; k++) r[9*l+k] = v[17 - 9*l - k];
    return r;
  endfunction

  function automatic logic [17:0] dec_b(logic [79:0] v);
    logic [17:0] r;
    for (int l = 0; l < NL; l++) for (int k = 0; k < W; k++) r[9*l+k] = v[53 - 9*l - k];
    return r;
  endfunction

  function automatic logic [1:0] dec_aoe(logic [79:0] v);
    return {v[73], v[77]};
  endfunction

  function automatic logic [1:0] dec_boe(logic [79:0] v);
    return {v[72], v[76]};
  endfunction

  task automatic pulse_cap();
    @(negedge clk); cap_en = 1'b1;
    @(negedge clk); cap_en = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_en = 1'b1;
    @(negedge clk); upd_en = 1'b0;
  endtask

  task automatic pulse_trst();
    @(negedge clk); tst_rst = 1'b1;
    @(negedge clk); tst_rst = 1'b0;
  endtask

  task automatic scan(input logic [79:0] vin, output logic [79:0] vout);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      vout[i] = tdo;
      tdi = vin[i];
      shf_en = 1'b1;
    end
    @(negedge clk);
    shf_en = 1'b0;
  endtask

  task automatic check_drive(input logic [79:0] v, input string req);
    #1;
    check(a_out == dec_a(v),   req, a_out, dec_a(v));
    check(b_out == dec_b(v),   req, b_out, dec_b(v));
    check(a_oe  == dec_aoe(v), req, a_oe,  dec_aoe(v));
    check(b_oe  == dec_boe(v), req, b_oe,  dec_boe(v));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [79:0] p1, p2, got;
    p1 = 80'hF0E1_D2C3_B4A5_9687_7869;
    p2 = 80'h3C5A_9E17_C2B8_60F4_D1A7;
    rst_n = 1'b0; drive_mode = 1'b0; cap_en = 1'b0; shf_en = 1'b0;
    upd_en = 1'b0; tst_rst = 1'b0; tdi = 1'b0;
    lane_oe_n = 2'b11; lane_dir = 2'b00; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);

    // R9: reset state, including drive-mode view of the cleared latches
    drive_mode = 1'b1;
    #1;
    check(tdo == 1'b0, "R9 tdo", tdo, 0);
    check_drive(80'h0, "R9 latches");
    @(negedge clk);
    rst_n = 1'b1;
    drive_mode = 1'b0;
    repeat (3) @(negedge clk);

    // R1, R2: normal-mode table
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      {lane_oe_n, lane_dir, a_in, b_in} = TBL[i][43:4];
      #1;
      check(a_oe == TBL[i][3:2], "R1/R2 a_oe", a_oe, TBL[i][3:2]);
      check(b_oe == TBL[i][1:0], "R1/R2 b_oe", b_oe, TBL[i][1:0]);
      check(a_out == b_in, "R2 a_out", a_out, b_in);
      check(b_out == a_in, "R2 b_out", b_out, a_in);
    end

    // R3, R4: capture, then scan out while scanning p1 in
    @(negedge clk);
    lane_oe_n = 2'b10; lane_dir = 2'b01; a_in = 18'h3C0F1; b_in = 18'h0B7E2;
    pulse_cap();
    #1;
    check(tdo == exp_cap(lane_oe_n, lane_dir, a_in, b_in)[0], "R4 tdo cell0", tdo,
          exp_cap(lane_oe_n, lane_dir, a_in, b_in)[0]);
    scan(p1, got);
    check(got == exp_cap(lane_oe_n, lane_dir, a_in, b_in), "R3 capture image", got,
          exp_cap(lane_oe_n, lane_dir, a_in, b_in));

    // R5: update then drive from latches
    pulse_upd();
    drive_mode = 1'b1;
    check_drive(p1, "R5 drive p1");

    // R6: normal mode ignores latches
    @(negedge clk);
    drive_mode = 1'b0;
    #1;
    check(a_out == b_in, "R6 a_out", a_out, b_in);
    check(b_out == a_in, "R6 b_out", b_out, a_in);
    check(a_oe == 2'b00, "R6 a_oe", a_oe, 2'b00);
    check(b_oe == 2'b01, "R6 b_oe", b_oe, 2'b01);

    // R7 and R4: scan p2 without update; p1 must come back out after 80 shifts
    @(negedge clk);
    drive_mode = 1'b1;
    scan(p2, got);
    check(got == p1, "R4 80-shift delay", got, p1);
    check_drive(p1, "R7 hold over shift");
    pulse_cap();
    check_drive(p1, "R7 hold over capture");

    // R5 with the second pattern (capture above overwrote the chain; rescan p2)
    scan(p2, got);
    pulse_upd();
    check_drive(p2, "R5 drive p2");

    // R8: test reset clears latches
    pulse_trst();
    check_drive(80'h0, "R8 test reset");

    // R8: test reset beats a simultaneous update
    scan(p1, got);
    @(negedge clk); tst_rst = 1'b1; upd_en = 1'b1;
    @(negedge clk); tst_rst = 1'b0; upd_en = 1'b0;
    check_drive(80'h0, "R8 priority");

    done = 1'b1;
    summary();
  end
endmodule